// File: doc/BRIEF.md
# Logarithmic-Depth Carry Prefix Adder

This block adds two unsigned N-bit operands and a carry-in and returns the N-bit sum and the carry-out, with no clock and no state. Every carry is produced at the same time by a parallel prefix tree of depth log2(N). At each tree level, each cell merges exactly two adjacent bit groups and drives at most two cells at the next level. The width is a parameter, 64 by default, and it must be a power of two.

The datapath has three stages. The first stage forms a generate bit and a propagate bit for each position, and it folds the carry-in into the generate of bit 0. The second stage is the prefix tree. It turns these pairs into group generates that run from each bit all the way down to the carry-in. The third stage forms each sum bit as the XOR of that bit's propagate and the carry coming out of the group just below it.

For N=64 the signal path is eight logic levels deep: one pair-forming layer, six tree levels and one sum layer. Some cells at a tree level already reach the carry-in. They keep only the generate result, because no later level needs their propagate.

Top module: `ks_adder`

## Requirements
- R1: For any operands and carry-in, {cout_o, sum_o} equals a_i + b_i + cin_i computed at N+1 bits.
- R2: At a bit where both operand bits are 1, the carry leaving that bit is 1 whatever the lower bits and the carry-in are. At a bit where both operand bits are 0, the carry leaving that bit is 0.
- R3: At a bit where the two operand bits differ, the carry leaving that bit equals the carry entering it.
- R4: The carry-in enters at bit 0. With both operands zero and cin_i=1, sum_o is 1 and cout_o is 0. With both operands zero and cin_i=0, sum_o is 0 and cout_o is 0.
- R5: All-ones plus one gives sum_o of zero and cout_o of 1. This holds both when the one comes from b_i and when it comes from cin_i.
- R6: A full-length propagate chain (b_i equal to the bitwise inverse of a_i) gives sum_o of all ones and cout_o of 0 when cin_i is 0. It gives sum_o of zero and cout_o of 1 when cin_i is 1.
- R7: The block is combinational. sum_o and cout_o reflect the current inputs within the same clock period in which the inputs change, with zero register stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
Every result is due zero cycles after its stimulus, because no register lies between the operand ports and the result ports. The bench drives a new vector on a rising edge and samples sum_o and cout_o half a period later, on the falling edge. By then the combinational path has settled, and the next vector has not yet been applied. The checker compares the carry vector against a bit-serial ripple recurrence, which is independent of how the tree is built.

// File: rtl/ks_pkg.sv
package ks_pkg;

  // One generate/propagate pair for a bit or a group of bits.
  typedef struct packed {
    logic g;
    logic p;
  } pg_t;

  // Merge an upper group with the adjacent lower group (both outputs kept).
  function automatic pg_t ks_black(input pg_t hi, input pg_t lo);
    pg_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // Merge when the lower group already reaches the carry-in: only generate.
  function automatic logic ks_grey(input pg_t hi, input logic lo_g);
    return hi.g | (hi.p & lo_g);
  endfunction

endpackage

// File: rtl/ks_pg_layer.sv
module ks_pg_layer
  import ks_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output pg_t  [WIDTH-1:0] seed_o,
  output logic [WIDTH-1:0] bit_p_o
);

  logic [WIDTH-1:0] bit_g;

  assign bit_g   = a_i & b_i;
  assign bit_p_o = a_i ^ b_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_seed
    if (i == 0) begin : g_fold
      // Carry-in treated as a generate at bit -1, folded into bit 0.
      assign seed_o[i].g = bit_g[0] | (bit_p_o[0] & cin_i);
      assign seed_o[i].p = 1'b0;
    end else begin : g_plain
      assign seed_o[i].g = bit_g[i];
      assign seed_o[i].p = bit_p_o[i];
    end
  end

endmodule

// File: rtl/ks_prefix_tree.sv
module ks_prefix_tree
  import ks_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  pg_t  [WIDTH-1:0] seed_i,
  output logic [WIDTH-1:0] grp_g_o
);

  localparam int LEVELS = $clog2(WIDTH);

  pg_t [WIDTH-1:0] stage [LEVELS+1];

  assign stage[0] = seed_i;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int DIST = 1 << lv;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i < DIST) begin : g_pass
        assign stage[lv+1][i] = stage[lv][i];
      end else if (i < 2 * DIST) begin : g_grey
        assign stage[lv+1][i].g = ks_grey(stage[lv][i], stage[lv][i-DIST].g);
        assign stage[lv+1][i].p = 1'b0;
      end else begin : g_black
        assign stage[lv+1][i] = ks_black(stage[lv][i], stage[lv][i-DIST]);
      end
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    assign grp_g_o[i] = stage[LEVELS][i].g;
  end

endmodule

// File: rtl/ks_sum_layer.sv
module ks_sum_layer #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] bit_p_i,
  input  logic [WIDTH:0]   carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  assign sum_o  = bit_p_i ^ carry_i[WIDTH-1:0];
  assign cout_o = carry_i[WIDTH];

endmodule

// File: rtl/ks_adder.sv
module ks_adder
  import ks_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  pg_t  [WIDTH-1:0] seed_w;
  logic [WIDTH-1:0] bit_p_w;
  logic [WIDTH-1:0] grp_g_w;
  // carry_w[i] is the carry into bit i; carry_w[WIDTH] is the carry-out.
  logic [WIDTH:0]   carry_w;

  ks_pg_layer #(.WIDTH(WIDTH)) u_pg (
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .seed_o  (seed_w),
    .bit_p_o (bit_p_w)
  );

  ks_prefix_tree #(.WIDTH(WIDTH)) u_tree (
    .seed_i  (seed_w),
    .grp_g_o (grp_g_w)
  );

  assign carry_w = {grp_g_w, cin_i};

  ks_sum_layer #(.WIDTH(WIDTH)) u_sum (
    .bit_p_i (bit_p_w),
    .carry_i (carry_w),
    .sum_o   (sum_o),
    .cout_o  (cout_o)
  );

endmodule

// File: rtl/ks_adder_chk.sv
module ks_adder_chk #(
  parameter int WIDTH = 64
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic [WIDTH:0]   carry_w
);

  logic [WIDTH:0] total;
  logic           known;

  assign total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
  assign known = !$isunknown({a_i, b_i, cin_i});

  always_comb begin
    if (known) begin
      p_full_sum_r1: assert ({cout_o, sum_o} == total)
        else $error("R1: sum mismatch");
      p_cin_entry_r4: assert (carry_w[0] == cin_i)
        else $error("R4: carry-in not at bit 0");
      for (int i = 0; i < WIDTH; i++) begin
        if (a_i[i] == b_i[i]) begin
          p_gen_kill_r2: assert (carry_w[i+1] == a_i[i])
            else $error("R2: generate/kill wrong at bit %0d", i);
        end else begin
          p_propagate_r3: assert (carry_w[i+1] == carry_w[i])
            else $error("R3: propagate wrong at bit %0d", i);
        end
      end
    end
  end

endmodule

bind ks_adder ks_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .cout_o  (cout_o),
  .carry_w (carry_w)
);

// File: tb/ks_adder_test.sv
module ks_adder_test;

  localparam int W = 64;
  localparam int NRAND = 10000;

  logic         clk = 1'b0;
  logic [W-1:0] a, b, sum;
  logic         cin, cout;
  int           errors = 0;
  int           checks = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  ks_adder #(.WIDTH(W)) uut (
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
  );

  // Reference: bit-serial ripple, independent of any prefix structure.
  function automatic logic [W:0] ref_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                         input logic c);
    logic [W:0] r;
    logic       cy;
    cy = c;
    for (int i = 0; i < W; i++) begin
      r[i] = x[i] ^ y[i] ^ cy;
      cy   = (x[i] & y[i]) | (cy & (x[i] | y[i]));
    end
    r[W] = cy;
    return r;
  endfunction

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c,
                       input string tag);
    logic [W:0] exp;
    @(posedge clk);
    a = x; b = y; cin = c;
    exp = ref_add(x, y, c);
    @(negedge clk);  // R7: result due in the same period, zero registers
    checks++;
    if ({cout, sum} !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%0d got=%h expected=%h", tag, x, y, c,
               {cout, sum}, exp);
    end
  endtask

  task automatic expect_out(input logic [W-1:0] es, input logic ec, input string tag);
    checks++;
    if (sum !== es || cout !== ec) begin
      errors++;
      $display("FAIL %s got=%0d/%h expected=%0d/%h", tag, cout, sum, ec, es);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] x, y, m;
    void'($urandom(32'h5eed_1234));
    a = '0; b = '0; cin = 1'b0;

    // R4: zero plus zero, and carry-in alone
    apply('0, '0, 1'b0, "R4 zero");
    expect_out('0, 1'b0, "R4 zero explicit");
    apply('0, '0, 1'b1, "R4 cin only");
    expect_out({{(W-1){1'b0}}, 1'b1}, 1'b0, "R4 cin only explicit");

    // R5: all ones plus one
    apply('1, {{(W-1){1'b0}}, 1'b1}, 1'b0, "R5 ones+b1");
    expect_out('0, 1'b1, "R5 ones+b1 explicit");
    apply('1, '0, 1'b1, "R5 ones+cin");
    expect_out('0, 1'b1, "R5 ones+cin explicit");

    // R6: full-length propagate chain
    apply({(W/2){2'b10}}, {(W/2){2'b01}}, 1'b0, "R6 chain cin0");
    expect_out('1, 1'b0, "R6 chain cin0 explicit");
    apply({(W/2){2'b10}}, {(W/2){2'b01}}, 1'b1, "R6 chain cin1");
    expect_out('0, 1'b1, "R6 chain cin1 explicit");
    apply('1, '0, 1'b0, "R6 ones+zero");
    apply({(W/2){2'b01}}, {(W/2){2'b01}}, 1'b1, "R1 alternating same");
    apply('1, '1, 1'b1, "R1 ones+ones+1");

    // R2: generate / kill at each position, random lower bits
    for (int i = 0; i < W; i++) begin
      x = {$urandom, $urandom}; y = {$urandom, $urandom};
      m = '1 << i;
      x = (x & ~m) | (m & ({W{1'b0}} | ({{(W-1){1'b0}},1'b1} << i)));
      y = (y & ~m) | ({{(W-1){1'b0}},1'b1} << i);
      apply(x, y, 1'($urandom), "R2 generate");
      x[i] = 1'b0; y[i] = 1'b0;
      apply(x, y, 1'($urandom), "R2 kill");
    end

    // R3: propagate run from bit 0 up to each position
    for (int i = 1; i <= W; i++) begin
      m = (i == W) ? '1 : (({{(W-1){1'b0}},1'b1} << i) - 1);
      x = {$urandom, $urandom};
      apply(x & m, ~x & m, 1'b1, "R3 propagate run");
    end

    // R1: random vectors, some biased toward long carry chains
    for (int n = 0; n < NRAND; n++) begin
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if (n % 4 == 1) y = ~x ^ ({{(W-1){1'b0}},1'b1} << ($urandom % W));
      apply(x, y, 1'($urandom), "R1 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule